// File: doc/BRIEF.md
# Burst Column Sequencer with Wrap

This block turns read and write commands aimed at an already open row into a stream of column addresses, one per clock, for the whole of a programmed burst. Each command carries a start column. The burst settings latched with the command fix the beat pattern. The length can be 1, 2, 4 or 8 beats, or full page. The order inside a length-aligned block can be sequential or interleaved. The first beat leaves the block in the same cycle as the command. Later beats follow on consecutive cycles.

For reads, the block delays a read output enable by the programmed read latency, so the enable is high exactly in the cycles in which read data is on the bus. For writes, it raises a capture strobe in each cycle whose write data belongs to the burst. This includes the command cycle.

A new read or write cuts the running burst short and starts over. A precharge to the bank of the running burst stops it. A stop command ends a full-page burst, which would otherwise circle the row without end. The array and all row and bank timing are handled elsewhere.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held low, and after it is released with no command issued, col_valid, wr_strobe and rd_oe are all 0.
- R2: A read command (cmd=1) places start_col on col_addr with col_valid=1 and col_is_wr=0 in the command cycle. rd_oe is high exactly rl cycles after each cycle that carries a read beat, with rl = mode_cl, where code 0 counts as 1 and codes 1 to 3 are used as given.
- R3: With sequential order (mode_ilv=0), beat k of a burst of length L addresses the block of L columns aligned to L that contains the start column. The offset within that block is (start offset + k) mod L. mode_bl codes 0, 1, 2, 3 select L = 1, 2, 4, 8.
- R4: With interleaved order (mode_ilv=1, L of 2 to 8), beat k has offset (start offset XOR k) within the same aligned block.
- R5: mode_bl[2]=1 selects full page. Beat k then addresses (start_col + k) mod 2^COL_W, the beats run without end, and mode_ilv has no effect.
- R6: A write command (cmd=2) gives col_valid=1, col_is_wr=1 and wr_strobe=1 in the command cycle with col_addr=start_col. Every later beat of that write burst also raises wr_strobe, and reads never do.
- R7: A burst of fixed length L makes exactly L beats on consecutive cycles and then falls idle. rd_oe therefore drops rl cycles after the last read beat.
- R8: A read or write in any cycle, for either bank, replaces the running burst in that cycle. A new read in the cycle right after the last beat of the previous read keeps rd_oe high with no gap.
- R9: A precharge (cmd=3) whose cmd_bank equals the bank of the running burst produces no beat in its cycle and ends the burst. Read data already in flight still appears. A precharge to the other bank leaves the burst running.
- R10: A stop command (cmd=4) ends a full-page burst with no beat in its cycle. During a fixed-length burst it is ignored and the beats continue unchanged.
- R11: Length and order are captured with each read or write command. Changing mode_bl or mode_ilv during a burst does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_bl | input | 3 | Burst length code: 0..3 give 1,2,4,8 beats; bit 2 set gives full page |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| mode_cl | input | CL_W | Read latency in cycles (0 counts as 1) |
| cmd | input | 3 | 0 idle, 1 read, 2 write, 3 precharge, 4 stop |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| start_col | input | COL_W | Start column of a read or write |
| col_valid | output | 1 | A beat is issued this cycle |
| col_addr | output | COL_W | Column of the current beat |
| col_is_wr | output | 1 | Current beat belongs to a write |
| wr_strobe | output | 1 | Capture write data this cycle |
| rd_oe | output | 1 | Read data is driven this cycle |

## Verification
The sharpest overlap is a command landing in the cycle where the running burst would emit its own next beat. This happens when a read arrives exactly at the last beat of the previous read, when a write cuts into a read, when a precharge or stop meets a live burst, or when a precharge targets the other bank. The bench schedules each of these collisions on purpose. A behavioural model decides every cycle which source owns col_addr and whether rd_oe must stay high across the seam. The model is compared with the outputs on every clock.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W  = 8,
  parameter int BANK_W = 1,
  parameter int CL_MAX = 3,
  parameter int CL_W   = $clog2(CL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_bl,
  input  logic              mode_ilv,
  input  logic [CL_W-1:0]   mode_cl,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  start_col,
  output logic              col_valid,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_is_wr,
  output logic              wr_strobe,
  output logic              rd_oe
);

  localparam logic [2:0] CMD_RD   = 3'd1;
  localparam logic [2:0] CMD_WR   = 3'd2;
  localparam logic [2:0] CMD_PRE  = 3'd3;
  localparam logic [2:0] CMD_STOP = 3'd4;

  logic              act_q, wr_q, ilv_q, fp_q;
  logic [1:0]        blc_q;
  logic [COL_W-1:0]  base_q, cnt_q;
  logic [BANK_W-1:0] bank_q;
  logic [CL_MAX:1]   oe_sr;

  logic              new_cmd, kill, cont, last;
  logic [COL_W-1:0]  mask_q, seq_a, ilv_a, burst_a;
  logic [CL_W-1:0]   cl_eff;

  assign new_cmd = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign kill    = ((cmd == CMD_PRE) && (cmd_bank == bank_q)) ||
                   ((cmd == CMD_STOP) && fp_q);
  assign cont    = act_q && !new_cmd && !kill;

  assign mask_q  = fp_q ? {COL_W{1'b1}} : ((COL_W'(1) << blc_q) - COL_W'(1));
  assign seq_a   = base_q + cnt_q;
  assign ilv_a   = base_q ^ cnt_q;
  assign burst_a = (base_q & ~mask_q) | (((ilv_q && !fp_q) ? ilv_a : seq_a) & mask_q);
  assign last    = !fp_q && (cnt_q == mask_q);

  assign col_valid = new_cmd || cont;
  assign col_addr  = new_cmd ? start_col : burst_a;
  assign col_is_wr = new_cmd ? (cmd == CMD_WR) : wr_q;
  assign wr_strobe = col_valid && col_is_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      ilv_q  <= 1'b0;
      fp_q   <= 1'b0;
      blc_q  <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      bank_q <= '0;
    end else if (new_cmd) begin
      act_q  <= mode_bl[2] || (mode_bl[1:0] != 2'd0);
      wr_q   <= (cmd == CMD_WR);
      ilv_q  <= mode_ilv;
      fp_q   <= mode_bl[2];
      blc_q  <= mode_bl[1:0];
      base_q <= start_col;
      cnt_q  <= COL_W'(1);
      bank_q <= cmd_bank;
    end else if (cont) begin
      cnt_q <= cnt_q + COL_W'(1);
      if (last) act_q <= 1'b0;
    end else if (kill) begin
      act_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) oe_sr <= '0;
    else        oe_sr <= {oe_sr[CL_MAX-1:1], col_valid && !col_is_wr};
  end

  assign cl_eff = (mode_cl == '0) ? CL_W'(1) :
                  ((int'(mode_cl) > CL_MAX) ? CL_W'(CL_MAX) : mode_cl);
  assign rd_oe  = oe_sr[cl_eff];

  p_rd_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD) |-> (col_valid && !col_is_wr && col_addr == start_col));

  p_oe_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_is_wr && cl_eff == CL_W'(1)) |=> (cl_eff != CL_W'(1) || rd_oe));

  p_wr_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WR) |-> (wr_strobe && col_addr == start_col));

  p_beat_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !fp_q) |-> (cnt_q != '0 && cnt_q <= mask_q));

  p_prech_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE && act_q && cmd_bank == bank_q) |=> !act_q);

  p_stop_fp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STOP && act_q && fp_q) |-> !col_valid);

  p_stop_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STOP && act_q && !fp_q) |-> col_valid);

endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int COL_W = 8;
  localparam int CL_W  = 2;
  localparam int PAGE  = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_bl = 3'd0;
  logic mode_ilv = 1'b0;
  logic [CL_W-1:0] mode_cl = 2'd2;
  logic [2:0] cmd = 3'd0;
  logic [0:0] cmd_bank = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic col_valid, col_is_wr, wr_strobe, rd_oe;
  logic [COL_W-1:0] col_addr;

  burst_col_seq #(.COL_W(COL_W), .BANK_W(1), .CL_MAX(3), .CL_W(CL_W)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .mode_bl(mode_bl), .mode_ilv(mode_ilv), .mode_cl(mode_cl),
    .cmd(cmd), .cmd_bank(cmd_bank), .start_col(start_col),
    .col_valid(col_valid), .col_addr(col_addr), .col_is_wr(col_is_wr),
    .wr_strobe(wr_strobe), .rd_oe(rd_oe));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  int m_act = 0, m_wr = 0, m_ilv = 0, m_len = 1, m_base = 0, m_cnt = 0, m_bank = 0;
  bit hist [1:8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int beat_addr(input int k);
    int blk, off, o;
    if (m_len == PAGE) return (m_base + k) % PAGE;
    blk = m_base - (m_base % m_len);
    off = m_base % m_len;
    o = m_ilv ? (off ^ k) : ((off + k) % m_len);
    return blk + o;
  endfunction

  task automatic step(input int c, input int bank, input int col);
    int e_v, e_a, e_w, rl, len_new;
    bit kill;
    @(negedge clk);
    cmd = 3'(c); cmd_bank = 1'(bank); start_col = COL_W'(col);
    #2;
    kill = (c == 3 && m_bank == bank) || (c == 4 && m_len == PAGE);
    e_v = 0; e_a = 0; e_w = 0;
    if (c == 1 || c == 2) begin
      e_v = 1; e_a = col; e_w = (c == 2);
    end else if (m_act != 0 && !kill) begin
      e_v = 1; e_a = beat_addr(m_cnt); e_w = m_wr;
    end
    rl = (mode_cl == 0) ? 1 : int'(mode_cl);
    if (rst_n) begin
      chk(col_valid == 1'(e_v), tag, col_valid, e_v);
      if (e_v != 0) begin
        chk(int'(col_addr) == e_a, tag, col_addr, e_a);
        chk(col_is_wr == 1'(e_w), "R6", col_is_wr, e_w);
      end
      chk(wr_strobe == 1'(e_v & e_w), "R6", wr_strobe, e_v & e_w);
      chk(rd_oe == hist[rl], "R2", rd_oe, hist[rl]);
    end
    for (int i = 8; i > 1; i--) hist[i] = hist[i-1];
    hist[1] = (e_v != 0) && (e_w == 0);
    if (c == 1 || c == 2) begin
      len_new = mode_bl[2] ? PAGE : (1 << mode_bl[1:0]);
      m_len = len_new; m_ilv = (len_new == PAGE) ? 0 : int'(mode_ilv);
      m_base = col; m_cnt = 1; m_act = (len_new > 1); m_wr = (c == 2); m_bank = bank;
    end else if (e_v != 0) begin
      m_cnt++;
      if (m_len == PAGE) m_cnt = m_cnt % PAGE;
      else if (m_cnt == m_len) m_act = 0;
    end else if (kill) m_act = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 1; i <= 8; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    #2;
    chk(!col_valid && !wr_strobe && !rd_oe, "R1", {col_valid, wr_strobe, rd_oe}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; idle(3);

    tag = "R3"; mode_cl = 2; mode_bl = 3'd2; mode_ilv = 0;
    step(1, 0, 6); idle(6);
    mode_bl = 3'd3; step(1, 0, 13); idle(8);
    mode_bl = 3'd0; step(1, 0, 40); idle(3);

    tag = "R4"; mode_cl = 3; mode_bl = 3'd3; mode_ilv = 1;
    step(1, 0, 13); idle(10);
    mode_bl = 3'd2; step(1, 1, 2); idle(6);

    tag = "R6"; mode_ilv = 0; mode_bl = 3'd1;
    step(2, 0, 9); idle(3);
    mode_bl = 3'd0; step(2, 0, 17); idle(2);
    mode_bl = 3'd3; mode_ilv = 1; step(2, 1, 30); idle(9);

    tag = "R8"; mode_ilv = 0; mode_bl = 3'd1; mode_cl = 2;
    step(1, 0, 4); step(0, 0, 0); step(1, 1, 7); step(0, 0, 0); step(1, 0, 20); idle(5);
    mode_bl = 3'd3; step(1, 0, 0); idle(2); step(1, 1, 50); idle(2);
    step(2, 0, 60); idle(2); step(1, 1, 70); idle(10);

    tag = "R9"; step(1, 0, 80); idle(2); step(3, 1, 0); step(0, 0, 0); step(3, 0, 0); idle(6);
    step(2, 1, 90); step(0, 0, 0); step(3, 1, 0); idle(4);

    tag = "R10"; mode_bl = 3'd2; step(1, 0, 100); step(4, 0, 0); idle(5);

    tag = "R5"; mode_bl = 3'd4; mode_ilv = 1; mode_cl = 1;
    step(1, 0, 250); idle(12); step(4, 1, 0); idle(4);
    mode_bl = 3'd7; step(2, 1, 3); idle(PAGE + 4); step(4, 0, 0); idle(3);

    tag = "R11"; mode_bl = 3'd3; mode_ilv = 0; mode_cl = 0;
    step(1, 0, 43); step(0, 0, 0); mode_bl = 3'd1; mode_ilv = 1;
    step(0, 0, 0); mode_bl = 3'd4; idle(8);

    tag = "R7"; mode_bl = 3'd2; mode_cl = 3; mode_ilv = 0;
    step(1, 0, 3); idle(8);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule